// File: doc/BRIEF.md
# SIMD Divergence Mask Controller

This block keeps the active-lane mask of one SIMD wavefront while it runs structured control flow. An instruction sequencer reports each control event with a one-cycle strobe. The events are: open a conditional with a per-lane predicate, switch to the alternate path, close the conditional, open a loop, test the loop with a per-lane predicate, and close the loop. The controller narrows, inverts or restores the mask. It saves the enclosing mask, and the set of lanes that took the branch, on a parameterized nesting stack.

After every accepted event the controller returns two results one cycle later: the new active mask and a skip flag. Skip is raised when no lane is active on the path that follows. The sequencer then bypasses that path instead of issuing it. After a loop test, skip means the loop has finished. Illegal nesting sets a sticky error flag and leaves the mask and the stack alone.

Top module: `simd_mask_ctrl`

## Requirements
- R1: After reset, every lane is active, skip and err are low, and the nesting stack is empty.
- R2: ev_op codes are 1 IF, 2 ELSE, 3 ENDIF, 4 LOOP_BEGIN, 5 LOOP_TEST and 6 LOOP_END. On an IF event the next mask is the current mask AND ev_cond. The enclosing mask and that result are pushed as one stack entry.
- R3: On ELSE the mask becomes the saved enclosing mask AND NOT the saved taken set. Only lanes that were active at the matching IF and failed its predicate are enabled.
- R4: On ENDIF the entry is popped and the mask returns to the value it had just before the matching IF.
- R5: After every accepted event, skip is 1 exactly when the new mask is all zero. When all active lanes agree, one of the two paths of a conditional is flagged for skipping. When they disagree, neither path is skipped.
- R6: LOOP_BEGIN pushes the current mask and leaves the mask unchanged. Each LOOP_TEST replaces the mask with mask AND ev_cond. Skip rises, signalling loop exit, only once no lane remains.
- R7: LOOP_END pops the entry and restores the mask held at LOOP_BEGIN.
- R8: An IF or LOOP_BEGIN while DEPTH entries are held sets err. The mask and the stack are left unchanged.
- R9: An ELSE, ENDIF or LOOP_END with an empty stack sets err and leaves the mask unchanged. Once set, err stays high until reset.
- R10: While ev_valid is low, or ev_op is 0 or 7, the mask, skip and stack do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Control event strobe |
| ev_op | input | 3 | Event code (see R2) |
| ev_cond | input | LANES | Per-lane predicate for IF and LOOP_TEST |
| active_mask | output | LANES | Current active-lane mask |
| skip | output | 1 | Next path has no active lanes |
| err | output | 1 | Sticky nesting error |

## Verification
The assertions assume that the sequencer holds ev_valid low during reset. They also assume that ev_op and ev_cond are settled while ev_valid is high, and that events arrive at most one per cycle. The bench drives every event on the falling edge, keeps the strobe for exactly one cycle, and drops it before sampling. The bench uses four lanes and three levels. It sweeps every pair of outer and inner predicates through nested conditionals, and every entry mask through a loop whose predicate loses one lane per test. It then runs deliberate overflow and underflow sequences to exercise the error path.

// File: rtl/simd_mask_pkg.sv
package simd_mask_pkg;
    typedef enum logic [2:0] {
        EV_NOP    = 3'd0,
        EV_IF     = 3'd1,
        EV_ELSE   = 3'd2,
        EV_ENDIF  = 3'd3,
        EV_LBEGIN = 3'd4,
        EV_LTEST  = 3'd5,
        EV_LEND   = 3'd6,
        EV_RSVD   = 3'd7
    } mask_ev_e;
endpackage

// File: rtl/simd_mask_stack.sv
module simd_mask_stack #(
    parameter int LANES = 64,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LANES-1:0] push_parent,
    input  logic [LANES-1:0] push_taken,
    output logic [LANES-1:0] top_parent,
    output logic [LANES-1:0] top_taken,
    output logic             empty,
    output logic             full
);
    localparam int LW = $clog2(DEPTH + 1);

    logic [LW-1:0]    lvl_d, lvl_q;
    logic [LANES-1:0] par_q [DEPTH];
    logic [LANES-1:0] tak_q [DEPTH];

    assign empty = (lvl_q == '0);
    assign full  = (lvl_q == LW'(DEPTH));

    always_comb begin
        lvl_d = lvl_q;
        if (push && !full)
            lvl_d = lvl_q + LW'(1);
        else if (pop && !empty)
            lvl_d = lvl_q - LW'(1);
    end

    always_comb begin
        top_parent = '0;
        top_taken  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (lvl_q == LW'(i + 1)) begin
                top_parent = par_q[i];
                top_taken  = tak_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                par_q[g] <= '0;
                tak_q[g] <= '0;
            end else if (push && !full && lvl_q == LW'(g)) begin
                par_q[g] <= push_parent;
                tak_q[g] <= push_taken;
            end
        end
    end

    a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    a_r9_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/simd_mask_eval.sv
module simd_mask_eval
    import simd_mask_pkg::*;
#(
    parameter int LANES = 64
) (
    input  logic             ev_valid,
    input  logic [2:0]       ev_op,
    input  logic [LANES-1:0] ev_cond,
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] top_parent,
    input  logic [LANES-1:0] top_taken,
    input  logic             empty,
    input  logic             full,
    output logic             accept,
    output logic             fault,
    output logic             push,
    output logic             pop,
    output logic [LANES-1:0] new_mask
);
    mask_ev_e op;
    assign op = mask_ev_e'(ev_op);

    always_comb begin
        accept   = 1'b0;
        fault    = 1'b0;
        push     = 1'b0;
        pop      = 1'b0;
        new_mask = cur_mask;
        if (ev_valid) begin
            unique case (op)
                EV_IF: begin
                    if (full) fault = 1'b1;
                    else begin
                        accept   = 1'b1;
                        push     = 1'b1;
                        new_mask = cur_mask & ev_cond;
                    end
                end
                EV_ELSE: begin
                    if (empty) fault = 1'b1;
                    else begin
                        accept   = 1'b1;
                        new_mask = top_parent & ~top_taken;
                    end
                end
                EV_ENDIF, EV_LEND: begin
                    if (empty) fault = 1'b1;
                    else begin
                        accept   = 1'b1;
                        pop      = 1'b1;
                        new_mask = top_parent;
                    end
                end
                EV_LBEGIN: begin
                    if (full) fault = 1'b1;
                    else begin
                        accept = 1'b1;
                        push   = 1'b1;
                    end
                end
                EV_LTEST: begin
                    accept   = 1'b1;
                    new_mask = cur_mask & ev_cond;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/simd_mask_ctrl.sv
module simd_mask_ctrl
    import simd_mask_pkg::*;
#(
    parameter int LANES = 64,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic [2:0]       ev_op,
    input  logic [LANES-1:0] ev_cond,
    output logic [LANES-1:0] active_mask,
    output logic             skip,
    output logic             err
);
    typedef struct packed {
        logic [LANES-1:0] mask;
        logic             skip;
        logic             err;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic [LANES-1:0] top_parent, top_taken, new_mask;
    logic             empty, full, accept, fault, push, pop;

    simd_mask_eval #(.LANES(LANES)) u_eval (
        .ev_valid  (ev_valid),
        .ev_op     (ev_op),
        .ev_cond   (ev_cond),
        .cur_mask  (ctl_q.mask),
        .top_parent(top_parent),
        .top_taken (top_taken),
        .empty     (empty),
        .full      (full),
        .accept    (accept),
        .fault     (fault),
        .push      (push),
        .pop       (pop),
        .new_mask  (new_mask)
    );

    simd_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .pop        (pop),
        .push_parent(ctl_q.mask),
        .push_taken (new_mask),
        .top_parent (top_parent),
        .top_taken  (top_taken),
        .empty      (empty),
        .full       (full)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (accept) begin
            ctl_d.mask = new_mask;
            ctl_d.skip = ~|new_mask;
        end
        if (fault)
            ctl_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.mask <= '1;
            ctl_q.skip <= 1'b0;
            ctl_q.err  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign active_mask = ctl_q.mask;
    assign skip        = ctl_q.skip;
    assign err         = ctl_q.err;

    a_r2_if_narrows: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_op == EV_IF && !full)
        |=> (active_mask & ~$past(active_mask)) == '0);
    a_r3_else_excludes_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_op == EV_ELSE && !empty)
        |=> (active_mask & $past(top_taken)) == '0);
    a_r4_endif_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_op == EV_ENDIF && !empty)
        |=> active_mask == $past(top_parent));
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> ($stable(active_mask) && $stable(skip)));
endmodule

// File: tb/simd_mask_ctrl_test.sv
module simd_mask_ctrl_test;
    localparam int L = 4;
    localparam int D = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ev_valid = 1'b0;
    logic [2:0]   ev_op = 3'd0;
    logic [L-1:0] ev_cond = '0;
    logic [L-1:0] active_mask;
    logic         skip, err;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    simd_mask_ctrl #(.LANES(L), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_op(ev_op),
        .ev_cond(ev_cond), .active_mask(active_mask), .skip(skip), .err(err)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ev(input logic [2:0] op, input logic [L-1:0] c, input logic v = 1'b1);
        @(negedge clk);
        ev_valid = v;
        ev_op    = op;
        ev_cond  = c;
        @(posedge clk);
        #1;
        ev_valid = 1'b0;
        ev_op    = 3'd0;
        ev_cond  = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [L-1:0] m;
        do_reset();
        chk("R1 mask", 8'(active_mask), 8'hF);
        chk("R1 skip", 8'(skip), 8'h0);
        chk("R1 err", 8'(err), 8'h0);

        // R2 R3 R4 R5: nested conditional sweep
        for (int a = 0; a < 16; a++) begin
            ev(3'd1, L'(a));
            chk("R2 outer if", 8'(active_mask), 8'(a));
            chk("R5 outer skip", 8'(skip), 8'(a == 0));
            for (int b = 0; b < 16; b++) begin
                ev(3'd1, L'(b));
                chk("R2 inner if", 8'(active_mask), 8'(a & b));
                chk("R5 if skip", 8'(skip), 8'((a & b) == 0));
                ev(3'd2, '0);
                chk("R3 else", 8'(active_mask), 8'(a & ~b & 15));
                chk("R5 else skip", 8'(skip), 8'((a & ~b & 15) == 0));
                ev(3'd3, '0);
                chk("R4 inner endif", 8'(active_mask), 8'(a));
            end
            ev(3'd3, '0);
            chk("R4 outer endif", 8'(active_mask), 8'hF);
            chk("R1 no err", 8'(err), 8'h0);
        end

        // R6 R7: loop, one lane dropped per test
        for (int a = 0; a < 16; a++) begin
            ev(3'd1, L'(a));
            ev(3'd4, '0);
            chk("R6 loop begin", 8'(active_mask), 8'(a));
            m = L'(a);
            ev(3'd5, 4'hF);
            chk("R6 test all-true", 8'(active_mask), 8'(a));
            for (int k = 1; k <= 4; k++) begin
                m = m & L'(4'hF >> k);
                ev(3'd5, L'(4'hF >> k));
                chk("R6 test mask", 8'(active_mask), 8'(m));
                chk("R6 exit skip", 8'(skip), 8'(m == 0));
            end
            ev(3'd6, '0);
            chk("R7 loop end", 8'(active_mask), 8'(a));
            chk("R5 loop end skip", 8'(skip), 8'(a == 0));
            ev(3'd3, '0);
            chk("R7 outer restore", 8'(active_mask), 8'hF);
        end

        // R10: idle strobe, nop and reserved codes
        ev(3'd1, 4'b0110);
        ev(3'd1, 4'b0000, 1'b0);
        chk("R10 valid low", 8'(active_mask), 8'h6);
        ev(3'd0, 4'b0000);
        chk("R10 nop", 8'(active_mask), 8'h6);
        ev(3'd7, 4'b0000);
        chk("R10 reserved", 8'(active_mask), 8'h6);
        ev(3'd3, '0);
        chk("R10 stack intact", 8'(active_mask), 8'hF);
        chk("R10 no err", 8'(err), 8'h0);

        // R8 overflow
        ev(3'd1, 4'b1110);
        ev(3'd4, '0);
        ev(3'd1, 4'b0111);
        chk("R8 at depth", 8'(active_mask), 8'h6);
        chk("R8 no err yet", 8'(err), 8'h0);
        ev(3'd1, 4'b0010);
        chk("R8 overflow err", 8'(err), 8'h1);
        chk("R8 mask held", 8'(active_mask), 8'h6);
        ev(3'd3, '0);
        chk("R8 top kept", 8'(active_mask), 8'hE);
        chk("R9 err sticky", 8'(err), 8'h1);
        do_reset();
        chk("R1 err cleared", 8'(err), 8'h0);

        // R9 underflow
        ev(3'd3, '0);
        chk("R9 endif empty err", 8'(err), 8'h1);
        chk("R9 mask held", 8'(active_mask), 8'hF);
        do_reset();
        ev(3'd2, '0);
        chk("R9 else empty err", 8'(err), 8'h1);
        chk("R9 else mask held", 8'(active_mask), 8'hF);
        do_reset();
        ev(3'd6, '0);
        chk("R9 loop end empty err", 8'(err), 8'h1);
        ev(3'd1, 4'b0101);
        chk("R9 still sticky", 8'(err), 8'h1);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule